// File: doc/BRIEF.md
# Dual-Output Masked Interrupt Controller

This block gathers a vector of level-sensitive interrupt request lines and turns them into two processor requests: a normal interrupt and a fast interrupt. Each request has its own enable mask over the same raw source vector. Software changes a mask only by writing ones to a set register or a clear register. It never writes the mask directly, so a bit can change without a read-modify-write sequence.

Source 0 has a second use. Software can hold it asserted through a latch that it sets and clears. The raw value of source 0 is the OR of the external line and that latch. A simple synchronous register port with a word index, read and write strobes and 32-bit data gives software the raw status, the masked status for each output, and both masks. Both processor outputs are registered.

Top module: `dual_irq_ctl`

## Requirements
- R1: After reset both enable masks and the software latch are 0, both interrupt outputs are low, and a read of index 2, 4 or 10 returns 0.
- R2: A read strobe at a clock edge loads `reg_rdata` at that edge. Index 0 returns raw AND normal mask. Index 1 and index 9 return the raw vector. Index 2 returns the normal mask. Index 8 returns raw AND fast mask. Index 10 returns the fast mask.
- R3: A write to index 2 ORs the written value into the normal mask.
- R4: A write to index 3 clears every normal-mask bit that is 1 in the written value and leaves the other bits unchanged.
- R5: A write to index 10 ORs the written value into the fast mask. A write to index 11 clears every fast-mask bit that is 1 in the written value.
- R6: `cpu_irq` equals (raw AND normal mask) != 0. It reflects a line level or register write sampled at a clock edge right after that same edge.
- R7: `cpu_fiq` equals (raw AND fast mask) != 0, with the same timing as R6. A source enabled in both masks raises both outputs in the same cycle.
- R8: Raw bit n follows line n for n > 0. Raw bit 0 is line 0 OR the software latch. A write to index 4 with data bit 0 = 1 sets the latch. A write to index 5 with data bit 0 = 1 clears it. A write to either index with data bit 0 = 0 leaves the latch unchanged.
- R9: A read of index 4 returns raw bit 0 in bit 0 and zeros elsewhere. Reads of indices 3, 5, 11 and every index not listed in R2 return 0.
- R10: Writes to indices 0, 1, 8, 9 and to every index not named in R3, R4, R5 and R8 change neither mask nor the latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_lines | input | 32 | Level-sensitive interrupt request lines |
| reg_idx | input | 6 | Word index of the register accessed |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, loaded at the edge that samples `reg_rd` |
| cpu_irq | output | 1 | Normal interrupt request to the processor |
| cpu_fiq | output | 1 | Fast interrupt request to the processor |

## Verification
Every result of this block is due exactly one clock edge after its stimulus. Read data is loaded at the edge that samples the read strobe. A line change or a mask or latch write shows on both interrupt outputs right after the edge that samples it, because the outputs are computed from the next mask values. The driver applies each stimulus on a falling edge and queues the expected outputs, tagged with the number of the next rising edge. The monitor compares them on the falling edge that follows that rising edge, half a period clear of any change.

// File: rtl/dual_irq_ctl.sv
module dual_irq_ctl #(
  parameter int NSRC = 32,
  parameter int AW   = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_lines,
  input  logic [AW-1:0]   reg_idx,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [NSRC-1:0] reg_wdata,
  output logic [NSRC-1:0] reg_rdata,
  output logic            cpu_irq,
  output logic            cpu_fiq
);

  localparam logic [AW-1:0] IX_NSTAT = AW'(0);
  localparam logic [AW-1:0] IX_NRAW  = AW'(1);
  localparam logic [AW-1:0] IX_NSET  = AW'(2);
  localparam logic [AW-1:0] IX_NCLR  = AW'(3);
  localparam logic [AW-1:0] IX_SWSET = AW'(4);
  localparam logic [AW-1:0] IX_SWCLR = AW'(5);
  localparam logic [AW-1:0] IX_FSTAT = AW'(8);
  localparam logic [AW-1:0] IX_FRAW  = AW'(9);
  localparam logic [AW-1:0] IX_FSET  = AW'(10);
  localparam logic [AW-1:0] IX_FCLR  = AW'(11);
  localparam logic [NSRC-1:0] ZERO   = '0;

  logic [NSRC-1:0] nen, fen, nen_nx, fen_nx;
  logic            sw_hold, sw_nx;
  logic [NSRC-1:0] raw_now, raw_nx;

  assign raw_now = src_lines | {ZERO[NSRC-1:1], sw_hold};
  assign raw_nx  = src_lines | {ZERO[NSRC-1:1], sw_nx};

  always_comb begin
    nen_nx = nen;
    fen_nx = fen;
    sw_nx  = sw_hold;
    if (reg_wr) begin
      case (reg_idx)
        IX_NSET:  nen_nx = nen | reg_wdata;
        IX_NCLR:  nen_nx = nen & ~reg_wdata;
        IX_FSET:  fen_nx = fen | reg_wdata;
        IX_FCLR:  fen_nx = fen & ~reg_wdata;
        IX_SWSET: if (reg_wdata[0]) sw_nx = 1'b1;
        IX_SWCLR: if (reg_wdata[0]) sw_nx = 1'b0;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nen     <= '0;
      fen     <= '0;
      sw_hold <= 1'b0;
      cpu_irq <= 1'b0;
      cpu_fiq <= 1'b0;
    end else begin
      nen     <= nen_nx;
      fen     <= fen_nx;
      sw_hold <= sw_nx;
      cpu_irq <= |(raw_nx & nen_nx);
      cpu_fiq <= |(raw_nx & fen_nx);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_idx)
        IX_NSTAT:         reg_rdata <= raw_now & nen;
        IX_NRAW, IX_FRAW: reg_rdata <= raw_now;
        IX_NSET:          reg_rdata <= nen;
        IX_SWSET:         reg_rdata <= {ZERO[NSRC-1:1], raw_now[0]};
        IX_FSTAT:         reg_rdata <= raw_now & fen;
        IX_FSET:          reg_rdata <= fen;
        default:          reg_rdata <= '0;
      endcase
    end
  end

  AST_NSET_ORS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_idx == IX_NSET) |=> ((nen & $past(reg_wdata)) == $past(reg_wdata))); // R3
  AST_NCLR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_idx == IX_NCLR) |=> ((nen & $past(reg_wdata)) == '0)); // R4
  AST_FSET_ORS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_idx == IX_FSET) |=> ((fen & $past(reg_wdata)) == $past(reg_wdata))); // R5
  AST_FCLR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_idx == IX_FCLR) |=> ((fen & $past(reg_wdata)) == '0)); // R5
  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (nen == '0) |-> !cpu_irq); // R6
  AST_FIQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (fen == '0) |-> !cpu_fiq); // R7
  AST_SW_SET_RAW0: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_idx == IX_SWSET && reg_wdata[0]) |=> raw_now[0]); // R8
  AST_UNDEF_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_idx > IX_FCLR) |=> (reg_rdata == '0)); // R9
  AST_STATUS_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_idx == IX_NSTAT || reg_idx == IX_NRAW || reg_idx == IX_FSTAT || reg_idx == IX_FRAW))
    |=> ($stable(nen) && $stable(fen) && $stable(sw_hold))); // R10

endmodule

// File: tb/dual_irq_ctl_tb.sv
module dual_irq_ctl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_lines = '0;
  logic [5:0]  reg_idx = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cpu_irq, cpu_fiq;

  always #10 clk = ~clk;

  dual_irq_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .src_lines(src_lines), .reg_idx(reg_idx),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cpu_irq(cpu_irq), .cpu_fiq(cpu_fiq));

  typedef struct {
    int          due;
    bit          chk_rd;
    logic [31:0] exp_rd;
    logic        exp_irq;
    logic        exp_fiq;
    string       req;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [31:0] m_nen = '0, m_fen = '0;
  logic        m_sw = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      item_t it;
      it = q.pop_front();
      n_chk++;
      if (cpu_irq !== it.exp_irq || cpu_fiq !== it.exp_fiq) begin
        n_fail++;
        $display("FAIL %s irq/fiq actual %b%b expected %b%b", it.req, cpu_irq, cpu_fiq, it.exp_irq, it.exp_fiq);
      end
      if (it.chk_rd) begin
        n_chk++;
        if (reg_rdata !== it.exp_rd) begin
          n_fail++;
          $display("FAIL %s rdata actual %h expected %h", it.req, reg_rdata, it.exp_rd);
        end
      end
    end
  end

  task automatic step(input bit wr, input bit rd, input int idx, input logic [31:0] wd,
                      input logic [31:0] lines, input string req);
    item_t it;
    logic [31:0] raw;
    @(negedge clk);
    reg_wr = wr; reg_rd = rd; reg_idx = 6'(idx); reg_wdata = wd; src_lines = lines;
    raw = lines | {31'b0, m_sw};
    it.exp_rd = '0;
    if (rd) begin
      case (idx)
        0: it.exp_rd = raw & m_nen;
        1, 9: it.exp_rd = raw;
        2: it.exp_rd = m_nen;
        4: it.exp_rd = {31'b0, raw[0]};
        8: it.exp_rd = raw & m_fen;
        10: it.exp_rd = m_fen;
        default: it.exp_rd = '0;
      endcase
    end
    if (wr) begin
      case (idx)
        2: m_nen = m_nen | wd;
        3: m_nen = m_nen & ~wd;
        10: m_fen = m_fen | wd;
        11: m_fen = m_fen & ~wd;
        4: if (wd[0]) m_sw = 1'b1;
        5: if (wd[0]) m_sw = 1'b0;
        default: ;
      endcase
    end
    raw = lines | {31'b0, m_sw};
    it.due = cyc + 1;
    it.chk_rd = rd;
    it.exp_irq = |(raw & m_nen);
    it.exp_fiq = |(raw & m_fen);
    it.req = req;
    q.push_back(it);
  endtask

  task automatic wr(input int idx, input logic [31:0] wd, input logic [31:0] lines, input string req);
    step(1'b1, 1'b0, idx, wd, lines, req);
  endtask

  task automatic rd(input int idx, input logic [31:0] lines, input string req);
    step(1'b0, 1'b1, idx, '0, lines, req);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(2, 32'h0, "R1"); rd(10, 32'h0, "R1"); rd(4, 32'h0, "R1");
    rd(0, 32'hFFFF_FFFF, "R1");
    wr(2, 32'h0000_0020, 32'h20, "R3 R6");
    rd(0, 32'h20, "R2"); rd(1, 32'h20, "R2");
    wr(2, 32'h0000_0100, 32'h20, "R3");
    rd(2, 32'h20, "R3");
    wr(3, 32'h0000_0020, 32'h20, "R4 R6");
    rd(2, 32'h20, "R4");
    wr(10, 32'h0000_0020, 32'h20, "R5 R7");
    rd(8, 32'h20, "R2"); rd(9, 32'h20, "R2"); rd(10, 32'h20, "R5");
    step(1'b0, 1'b0, 0, '0, 32'h0, "R7");
    wr(2, 32'h0000_0020, 32'h0, "R3");
    step(1'b0, 1'b0, 0, '0, 32'h20, "R7 both rise");
    step(1'b0, 1'b0, 0, '0, 32'h0, "R7 both fall");
    wr(11, 32'h0000_0020, 32'h20, "R5 R7");
    rd(10, 32'h20, "R5");
    wr(3, 32'hFFFF_FFFF, 32'h0, "R4");
    wr(2, 32'h0000_0001, 32'h0, "R8");
    wr(4, 32'hFFFF_FFFE, 32'h0, "R8 bit0 clear ignored");
    rd(4, 32'h0, "R9");
    wr(4, 32'h0000_0001, 32'h0, "R8 set");
    rd(4, 32'h0, "R9"); rd(1, 32'h8000_0000, "R8 R2");
    wr(5, 32'hFFFF_FFFE, 32'h0, "R8 clear ignored");
    wr(5, 32'h0000_0001, 32'h0, "R8 clear");
    step(1'b0, 1'b0, 0, '0, 32'h1, "R8 external line0");
    rd(4, 32'h1, "R9");
    rd(3, 32'h1, "R9"); rd(5, 32'h1, "R9"); rd(11, 32'h1, "R9");
    rd(7, 32'h1, "R9"); rd(63, 32'h1, "R9");
    wr(10, 32'h0000_0003, 32'h0, "R5");
    foreach (q[i]) ;
    wr(0, 32'hFFFF_FFFF, 32'h2, "R10"); wr(1, 32'hFFFF_FFFF, 32'h2, "R10");
    wr(8, 32'hFFFF_FFFF, 32'h2, "R10"); wr(9, 32'hFFFF_FFFF, 32'h2, "R10");
    wr(6, 32'hFFFF_FFFF, 32'h2, "R10"); wr(40, 32'hFFFF_FFFF, 32'h2, "R10");
    rd(2, 32'h2, "R10"); rd(10, 32'h2, "R10"); rd(4, 32'h2, "R10");
    step(1'b0, 1'b0, 0, '0, 32'h0, "R6");
    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL scoreboard left %0d items", q.size());
    end
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule